// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block folds several reset requests into one internal reset for a small controller core: a power-on pulse, a watchdog overflow, a decoded illegal instruction, a STOP instruction while STOP is not enabled, and a low level on the board reset pin. For a power-on event it first keeps the CPU and module clocks off while the crystal oscillator settles. It then lets go of the open-drain reset pin, and a fixed number of cycles later it releases the CPU and memories so that the reset vector fetch can begin. Every internally generated reset pulls the pin low for one phase and then holds the CPU for a second phase.

The cause of the most recent reset is kept in a one-hot status register. Reading it clears it. The watchdog can be blocked by a configuration bit or by test-voltage indications in monitor and break conditions. The block reports whether the watchdog is currently allowed to act. All inputs are synchronous to `clk_i`, which is the crystal clock. The hardware reset `rst_ni` puts the block in an idle state that waits for the power-on pulse.

Top module: `rst_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are: pin drive 1, CPU reset 1, CPU clocks off, clock-output enable 0, and status 0000.
- R2: After the clock edge that samples `por_i` high, `clk_en_o` stays low for STAB_CYC cycles and goes high in the following cycle.
- R3: After a power-on, `rst_pin_drv_o` stays high until STAB_CYC+PHASE_CYC cycles after the sampling edge and drops in the next cycle.
- R4: `cpu_rst_o` is released exactly PHASE_CYC cycles after the pin drive drops. The pin is always released before the CPU.
- R5: `clkout_en_o` goes high in the first cycle of a power-on sequence and stays high from then on.
- R6: An enabled watchdog overflow starts a reset that drives the pin for PHASE_CYC cycles and holds the CPU for 2*PHASE_CYC cycles.
- R7: A watchdog overflow is ignored, and `cop_en_o` is low, when any of these holds: the disable configuration bit is 1; monitor mode is active with a test indication on the reset or IRQ pin; or a break is active with a test indication on the reset pin.
- R8: An illegal-opcode strobe starts a reset with the same timing as R6. A STOP strobe does the same while `stop_en_cfg_i` is 0, and has no effect while it is 1.
- R9: While the external pin is low in the run state, the CPU is held in reset and the pin is not driven. The CPU is released PHASE_CYC+1 cycles after the pin is seen high again.
- R10: The status is one-hot, with POR at bit 0, watchdog at bit 1, illegal opcode at bit 2 and external pin at bit 3. Each new reset sets its own bit and clears the others.
- R11: A cycle with `sts_rd_i` high clears the status on the next edge, unless a reset event arrives in the same cycle, in which case the event wins.
- R12: A power-on pulse restarts the full sequence from any state. Watchdog, illegal-opcode, STOP and pin requests are ignored while idle and while a reset sequence is running.
- R13: When requests arrive in the same cycle, power-on takes priority over the watchdog, the watchdog over an illegal opcode, and an illegal opcode over the external pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| por_i | input | 1 | Power-on pulse |
| cop_ovf_i | input | 1 | Watchdog overflow strobe |
| ilop_i | input | 1 | Illegal instruction strobe |
| stop_i | input | 1 | STOP instruction strobe |
| ext_rst_ni | input | 1 | Sampled level of the reset pin, active low |
| cop_off_cfg_i | input | 1 | Watchdog disable configuration bit |
| stop_en_cfg_i | input | 1 | STOP enable configuration bit |
| monitor_i | input | 1 | Monitor mode active |
| brk_i | input | 1 | Break state active |
| tst_rst_i | input | 1 | Test voltage seen on reset pin |
| tst_irq_i | input | 1 | Test voltage seen on IRQ pin |
| sts_rd_i | input | 1 | Status read strobe |
| clk_en_o | output | 1 | CPU and module clock enable |
| clkout_en_o | output | 1 | Clock-output enable |
| rst_pin_drv_o | output | 1 | Pull the reset pin low |
| cpu_rst_o | output | 1 | Reset to CPU and memories |
| cop_en_o | output | 1 | Watchdog permitted to reset |
| sts_o | output | 4 | Reset cause status |

## Verification
The assertions take three things for granted. All inputs change only between clock edges. A power-on pulse lasts one cycle. The external pin input does not read back the block's own drive. The stimulus follows these rules. Every strobe is raised at a falling edge and dropped at the next falling edge. The pin input is driven separately from `rst_pin_drv_o`. Test-voltage and mode inputs are set at least one cycle before the watchdog overflow they are meant to block.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_STAB, ST_PIN, ST_HOLD, ST_EXT, ST_RUN
  } seq_st_e;

  localparam int STS_W    = 4;
  localparam int STS_POR  = 0;
  localparam int STS_COP  = 1;
  localparam int STS_ILOP = 2;
  localparam int STS_PIN  = 3;

  typedef struct packed {
    logic por;
    logic cop;
    logic ilop;
    logic pin;
  } rst_evt_t;
endpackage

// File: rtl/rst_src_merge.sv
module rst_src_merge
  import rst_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     accept_i,
  input  logic     por_i,
  input  logic     cop_ovf_i,
  input  logic     ilop_i,
  input  logic     stop_i,
  input  logic     ext_low_i,
  input  logic     cop_off_cfg_i,
  input  logic     stop_en_cfg_i,
  input  logic     monitor_i,
  input  logic     brk_i,
  input  logic     tst_rst_i,
  input  logic     tst_irq_i,
  output logic     cop_en_o,
  output rst_evt_t evt_o
);
  logic tst_block, raw_cop, raw_ilop, raw_pin;

  always_comb begin
    tst_block = (monitor_i & (tst_rst_i | tst_irq_i)) | (brk_i & tst_rst_i);
    cop_en_o  = ~cop_off_cfg_i & ~tst_block;
    raw_cop   = accept_i & cop_ovf_i & cop_en_o;
    // disabled STOP is folded into the illegal-opcode path
    raw_ilop  = accept_i & (ilop_i | (stop_i & ~stop_en_cfg_i));
    raw_pin   = accept_i & ext_low_i;
    evt_o.por  = por_i;
    evt_o.cop  = raw_cop & ~por_i;
    evt_o.ilop = raw_ilop & ~por_i & ~raw_cop;
    evt_o.pin  = raw_pin & ~por_i & ~raw_cop & ~raw_ilop;
  end

  p_cop_cfg_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_off_cfg_i || (brk_i && tst_rst_i) || (monitor_i && tst_irq_i)) |-> !evt_o.cop);
  p_one_winner_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o));
  p_idle_ignore_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |-> !(evt_o.cop || evt_o.ilop || evt_o.pin));
endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC  = 4096,
  parameter int PHASE_CYC = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rst_evt_t evt_i,
  input  logic     ext_low_i,
  output seq_st_e  st_o,
  output logic     clk_en_o,
  output logic     clkout_en_o,
  output logic     pin_drv_o,
  output logic     cpu_rst_o
);
  localparam int MAX_CYC = (STAB_CYC > PHASE_CYC) ? STAB_CYC : PHASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] STAB_LAST  = CNT_W'(STAB_CYC - 1);
  localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(PHASE_CYC - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clkout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      clkout_q <= 1'b0;
    end else if (evt_i.por) begin
      st_q     <= ST_STAB;
      cnt_q    <= '0;
      clkout_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_STAB: begin
          if (cnt_q == STAB_LAST) begin st_q <= ST_PIN; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_PIN: begin
          if (cnt_q == PHASE_LAST) begin st_q <= ST_HOLD; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_HOLD: begin
          if (cnt_q == PHASE_LAST) begin st_q <= ST_RUN; cnt_q <= '0; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_EXT: begin
          if (!ext_low_i) begin st_q <= ST_HOLD; cnt_q <= '0; end
        end
        ST_RUN: begin
          if (evt_i.cop || evt_i.ilop) begin st_q <= ST_PIN; cnt_q <= '0; end
          else if (evt_i.pin) st_q <= ST_EXT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    st_o        = st_q;
    clk_en_o    = (st_q != ST_IDLE) && (st_q != ST_STAB);
    pin_drv_o   = (st_q == ST_IDLE) || (st_q == ST_STAB) || (st_q == ST_PIN);
    cpu_rst_o   = (st_q != ST_RUN);
    clkout_en_o = clkout_q;
  end

  p_pin_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drv_o) |-> cpu_rst_o);
  p_cpu_after_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> ($past(st_q) == ST_HOLD));
  p_stab_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.por |=> (!clk_en_o && pin_drv_o && cpu_rst_o));
  p_clkout_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkout_en_o |=> clkout_en_o);
  p_ext_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.pin |=> (!pin_drv_o && cpu_rst_o));
  p_int_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.cop || evt_i.ilop) |=> (pin_drv_o && clk_en_o));
endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg
  import rst_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rst_evt_t         evt_i,
  input  logic             rd_i,
  output logic [STS_W-1:0] sts_o
);
  logic [STS_W-1:0] sts_q, set_v;
  logic             any_evt;

  always_comb begin
    set_v           = '0;
    set_v[STS_POR]  = evt_i.por;
    set_v[STS_COP]  = evt_i.cop;
    set_v[STS_ILOP] = evt_i.ilop;
    set_v[STS_PIN]  = evt_i.pin;
    any_evt         = |set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sts_q <= '0;
    else if (any_evt) sts_q <= set_v;   // new cause replaces old
    else if (rd_i)    sts_q <= '0;
  end

  assign sts_o = sts_q;

  p_onehot_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |=> ($countones(sts_q) == 1));
  p_read_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !any_evt) |=> (sts_q == '0));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !any_evt) |=> $stable(sts_q));
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC  = 4096,
  parameter int PHASE_CYC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_i,
  input  logic             cop_ovf_i,
  input  logic             ilop_i,
  input  logic             stop_i,
  input  logic             ext_rst_ni,
  input  logic             cop_off_cfg_i,
  input  logic             stop_en_cfg_i,
  input  logic             monitor_i,
  input  logic             brk_i,
  input  logic             tst_rst_i,
  input  logic             tst_irq_i,
  input  logic             sts_rd_i,
  output logic             clk_en_o,
  output logic             clkout_en_o,
  output logic             rst_pin_drv_o,
  output logic             cpu_rst_o,
  output logic             cop_en_o,
  output logic [STS_W-1:0] sts_o
);
  rst_evt_t evt;
  seq_st_e  st;
  logic     accept;

  assign accept = (st == ST_RUN);

  rst_src_merge u_merge (
    .clk_i, .rst_ni,
    .accept_i      (accept),
    .por_i, .cop_ovf_i, .ilop_i, .stop_i,
    .ext_low_i     (~ext_rst_ni),
    .cop_off_cfg_i, .stop_en_cfg_i, .monitor_i, .brk_i, .tst_rst_i, .tst_irq_i,
    .cop_en_o,
    .evt_o         (evt)
  );

  rst_phase_fsm #(.STAB_CYC(STAB_CYC), .PHASE_CYC(PHASE_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .evt_i       (evt),
    .ext_low_i   (~ext_rst_ni),
    .st_o        (st),
    .clk_en_o,
    .clkout_en_o,
    .pin_drv_o   (rst_pin_drv_o),
    .cpu_rst_o
  );

  rst_status_reg u_sts (
    .clk_i, .rst_ni,
    .evt_i (evt),
    .rd_i  (sts_rd_i),
    .sts_o
  );
endmodule

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int STAB = 4096;
  localparam int PH   = 32;
  localparam int F_PIN = 0, F_CPU = 1, F_CLK = 2, F_STS = 3, F_COPEN = 4, F_CKO = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por_i = 0, cop_ovf_i = 0, ilop_i = 0, stop_i = 0, ext_rst_ni = 1;
  logic cop_off_cfg_i = 0, stop_en_cfg_i = 1, monitor_i = 0, brk_i = 0;
  logic tst_rst_i = 0, tst_irq_i = 0, sts_rd_i = 0;
  logic clk_en_o, clkout_en_o, rst_pin_drv_o, cpu_rst_o, cop_en_o;
  logic [3:0] sts_o;

  always #5 clk = ~clk;

  rst_seq #(.STAB_CYC(STAB), .PHASE_CYC(PH)) uut (
    .clk_i(clk), .rst_ni, .por_i, .cop_ovf_i, .ilop_i, .stop_i, .ext_rst_ni,
    .cop_off_cfg_i, .stop_en_cfg_i, .monitor_i, .brk_i, .tst_rst_i, .tst_irq_i,
    .sts_rd_i, .clk_en_o, .clkout_en_o, .rst_pin_drv_o, .cpu_rst_o, .cop_en_o, .sts_o
  );

  typedef struct {
    int    at;
    int    fld;
    int    val;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int probe(int fld);
    case (fld)
      F_PIN:   return int'(rst_pin_drv_o);
      F_CPU:   return int'(cpu_rst_o);
      F_CLK:   return int'(clk_en_o);
      F_STS:   return int'(sts_o);
      F_COPEN: return int'(cop_en_o);
      default: return int'(clkout_en_o);
    endcase
  endfunction

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--) begin
      if (exp_q[i].at == cyc) begin
        n_vec++;
        if (probe(exp_q[i].fld) != exp_q[i].val) begin
          n_bad++;
          $display("FAIL %s cyc %0d field %0d: got %0d expected %0d",
                   exp_q[i].req, cyc, exp_q[i].fld, probe(exp_q[i].fld), exp_q[i].val);
        end
        exp_q.delete(i);
      end
    end
  end

  task automatic expect_at(int at, int fld, int val, string req);
    exp_t e;
    e.at = at; e.fld = fld; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // expectations for a watchdog or illegal-opcode reset sampled at edge n+1
  task automatic int_seq(int n, int sts_v, string req);
    expect_at(n + 1, F_STS, sts_v, req);
    expect_at(n + PH, F_PIN, 1, req);
    expect_at(n + PH + 1, F_PIN, 0, req);
    expect_at(n + 2*PH, F_CPU, 1, req);
    expect_at(n + 2*PH + 1, F_CPU, 0, req);
  endtask

  task automatic read_clear();
    int n;
    @(negedge clk);
    n = cyc;
    sts_rd_i = 1;
    expect_at(n + 1, F_STS, 0, "R11");
    @(negedge clk);
    sts_rd_i = 0;
  endtask

  task automatic blocked_cop(string req);
    int n;
    @(negedge clk);
    n = cyc;
    expect_at(n + 1, F_COPEN, 0, req);
    cop_ovf_i = 1;
    expect_at(n + 2, F_PIN, 0, req);
    expect_at(n + 2, F_CPU, 0, req);
    expect_at(n + 2, F_STS, 0, req);
    @(negedge clk);
    cop_ovf_i = 0;
    wait_to(n + 4);
  endtask

  initial begin : drive
    int n, m;
    // R1 reset state
    repeat (2) @(negedge clk);
    n = cyc;
    expect_at(n + 1, F_PIN, 1, "R1");
    expect_at(n + 1, F_CPU, 1, "R1");
    expect_at(n + 1, F_CLK, 0, "R1");
    expect_at(n + 1, F_STS, 0, "R1");
    expect_at(n + 1, F_CKO, 0, "R1");
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R12 idle ignores watchdog
    n = cyc;
    cop_ovf_i = 1;
    @(negedge clk);
    cop_ovf_i = 0;
    expect_at(n + 3, F_STS, 0, "R12");
    expect_at(n + 3, F_CPU, 1, "R12");
    wait_to(n + 5);

    // power-on sequence R2 R3 R4 R5
    n = cyc;
    por_i = 1;
    expect_at(n + 1, F_CKO, 1, "R5");
    expect_at(n + 1, F_STS, 1, "R10");
    expect_at(n + STAB, F_CLK, 0, "R2");
    expect_at(n + STAB + 1, F_CLK, 1, "R2");
    expect_at(n + STAB + PH, F_PIN, 1, "R3");
    expect_at(n + STAB + PH + 1, F_PIN, 0, "R3");
    expect_at(n + STAB + 2*PH, F_CPU, 1, "R4");
    expect_at(n + STAB + 2*PH + 1, F_CPU, 0, "R4");
    expect_at(n + STAB + 2*PH + 5, F_CKO, 1, "R5");
    @(negedge clk);
    por_i = 0;
    wait_to(n + STAB + 2*PH + 8);

    // R6 watchdog reset; R10 replaces POR bit
    n = cyc;
    cop_ovf_i = 1;
    int_seq(n, 2, "R6");
    @(negedge clk);
    cop_ovf_i = 0;
    wait_to(n + 2*PH + 4);
    read_clear();

    // R11 event beats read; R8 illegal opcode
    n = cyc;
    ilop_i = 1;
    sts_rd_i = 1;
    int_seq(n, 4, "R8");
    expect_at(n + 2, F_STS, 4, "R11");
    @(negedge clk);
    ilop_i = 0;
    sts_rd_i = 0;
    wait_to(n + 2*PH + 4);
    read_clear();

    // R7 watchdog blocking conditions
    cop_off_cfg_i = 1;
    blocked_cop("R7");
    cop_off_cfg_i = 0;
    monitor_i = 1; tst_irq_i = 1;
    blocked_cop("R7");
    monitor_i = 0; tst_irq_i = 0;
    brk_i = 1; tst_rst_i = 1;
    blocked_cop("R7");
    brk_i = 0; tst_rst_i = 0;
    @(negedge clk);
    expect_at(cyc + 1, F_COPEN, 1, "R7");

    // R8 STOP enabled: no effect
    @(negedge clk);
    n = cyc;
    stop_i = 1;
    expect_at(n + 2, F_PIN, 0, "R8");
    expect_at(n + 2, F_CPU, 0, "R8");
    expect_at(n + 2, F_STS, 0, "R8");
    @(negedge clk);
    stop_i = 0;
    wait_to(n + 4);
    // R8 STOP disabled: illegal-opcode reset
    stop_en_cfg_i = 0;
    n = cyc;
    stop_i = 1;
    int_seq(n, 4, "R8");
    @(negedge clk);
    stop_i = 0;
    stop_en_cfg_i = 1;
    wait_to(n + 2*PH + 4);

    // R9 external pin
    n = cyc;
    ext_rst_ni = 0;
    expect_at(n + 1, F_STS, 8, "R9");
    expect_at(n + 1, F_CPU, 1, "R9");
    expect_at(n + 1, F_PIN, 0, "R9");
    expect_at(n + 6, F_PIN, 0, "R9");
    wait_to(n + 10);
    m = cyc;
    ext_rst_ni = 1;
    expect_at(m + PH, F_CPU, 1, "R9");
    expect_at(m + PH + 1, F_CPU, 0, "R9");
    wait_to(m + PH + 4);

    // R12 requests ignored during an active sequence
    n = cyc;
    cop_ovf_i = 1;
    int_seq(n, 2, "R12");
    @(negedge clk);
    cop_ovf_i = 0;
    wait_to(n + PH + 8);
    ilop_i = 1;
    ext_rst_ni = 0;
    @(negedge clk);
    ilop_i = 0;
    ext_rst_ni = 1;
    expect_at(n + PH + 12, F_STS, 2, "R12");
    wait_to(n + 2*PH + 4);

    // R13 simultaneous requests
    n = cyc;
    cop_ovf_i = 1; ilop_i = 1; ext_rst_ni = 0;
    int_seq(n, 2, "R13");
    @(negedge clk);
    cop_ovf_i = 0; ilop_i = 0; ext_rst_ni = 1;
    wait_to(n + 2*PH + 4);

    // R12 power-on restarts a running sequence
    n = cyc;
    cop_ovf_i = 1;
    @(negedge clk);
    cop_ovf_i = 0;
    wait_to(n + 10);
    por_i = 1;
    expect_at(n + 11, F_STS, 1, "R12");
    expect_at(n + 11, F_CLK, 0, "R12");
    expect_at(n + 10 + STAB + PH, F_PIN, 1, "R12");
    expect_at(n + 10 + STAB + PH + 1, F_PIN, 0, "R12");
    expect_at(n + 10 + STAB + 2*PH + 1, F_CPU, 0, "R12");
    @(negedge clk);
    por_i = 0;
    wait_to(n + 10 + STAB + 2*PH + 4);

    if (exp_q.size() != 0) begin
      n_bad += exp_q.size();
      $display("FAIL pending expectations: got %0d expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule